// File: doc/BRIEF.md
# Page-Buffered Parallel Nonvolatile Memory Write Engine

This block is a clocked model of the write side of a byte-wide nonvolatile memory whose host port looks asynchronous. The host drives active-low chip enable, write enable and output enable, an address and a data byte. The block samples these lines through a synchronizer and recognizes write cycles. For each cycle it latches the address when the cycle opens and the data when it closes. The bytes are gathered into a one-page buffer.

A page stays open for as long as the host keeps starting new byte loads inside a fixed inactivity window. When the window expires, the block runs a self-timed programming cycle. That cycle copies every buffered byte into the storage array, and the busy flag is high for its whole length. Writes that arrive during programming are dropped. A plain read path returns the stored byte at the sampled address whenever a read is requested.

Top module: `eeprom_page_loader`

## Requirements
- R1: After reset, `busy` and `dout_en` are low.
- R2: A write cycle is accepted only if, when chip enable and write enable first become both low, output enable is high. A cycle opened with output enable low stores nothing and starts no programming.
- R3: The address of a byte load is the one sampled when the later of chip enable and write enable falls. Address changes before that point or while the cycle is open have no effect.
- R4: The stored data is the value held just before the earlier of chip enable and write enable rises. Data presented after that edge has no effect.
- R5: Address bits above `PAGE_W` select the page and the low `PAGE_W` bits select the byte. The first accepted load fixes the page. A later load to a different page is ignored and does not restart the window.
- R6: Each accepted load restarts the window. Programming begins between `WIN_CYC` and `WIN_CYC`+8 clock cycles after the start of the last accepted load, so loads spaced closer than the window keep one page open without limit.
- R7: `busy` stays high for exactly `PROG_CYC` clock cycles. Once it falls, every buffered byte of the page can be read back from the array.
- R8: Write cycles that start while `busy` is high are ignored. They change no location and open no new page.
- R9: Only bytes loaded in the page are changed. A byte loaded more than once keeps its last value, and the other bytes of the page keep their old contents.
- R10: `dout_en` is high only while chip enable and output enable are low and write enable is high (after the input sampling delay). In that state `dout` shows the stored byte at the sampled address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data valid / drive enable |
| busy | output | 1 | Programming cycle in progress |

## Verification
The bench uses an 8-bit address and 3-bit page offsets, which gives 32 pages of 8 bytes. A 40-cycle window and a 24-cycle programming time are small enough that every page can be filled, programmed and read back in a short run. With these values the bench can sweep the whole array with both enable orderings on every write. It can also place load gaps close to the window edge, issue off-page and mid-programming writes, and check the exact programming length against simple arithmetic.

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int WIN_CYC  = 5000,
  parameter int PROG_CYC = 100000,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int BUS_W = 3 + ADDR_W + DATA_W;
  localparam int WC_W  = $clog2(WIN_CYC + 1);
  localparam int PC_W  = $clog2(PROG_CYC + 1);
  localparam logic [WC_W-1:0]  WIN_L   = WC_W'(WIN_CYC);
  localparam logic [PC_W-1:0]  PC_LAST = PC_W'(PROG_CYC - 1);
  localparam logic [PC_W-1:0]  PB_L    = PC_W'(PAGE_BYTES);
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  logic [SYNC_N-1:0][BUS_W-1:0] sync_q;
  logic              ce_s, we_s, oe_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s, din_q;
  logic              act_s, act_q;
  logic              start, stop, accept, commit;

  st_t               state;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic              cyc_open;
  logic [WC_W-1:0]   wcnt;
  logic [PC_W-1:0]   pcnt;
  logic [PAGE_BYTES-1:0] vld;
  logic [DATA_W-1:0] pbuf [PAGE_BYTES];
  logic [DATA_W-1:0] mem  [1 << ADDR_W];
  logic [PAGE_W-1:0] idx;
  logic              mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= BUS_IDLE;
    end else begin
      sync_q[0] <= {ce_n, we_n, oe_n, addr, din};
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {ce_s, we_s, oe_s, addr_s, din_s} = sync_q[SYNC_N-1];

  assign act_s  = !ce_s && !we_s;
  assign start  = act_s && !act_q && oe_s;
  assign stop   = !act_s && act_q;
  assign accept = start && ((state == S_IDLE) ||
                  (state == S_LOAD && addr_s[ADDR_W-1:PAGE_W] == page_q));
  assign commit = stop && cyc_open;
  assign busy   = (state == S_PROG);
  assign idx    = pcnt[PAGE_W-1:0];
  assign mem_we = busy && (pcnt < PB_L) && vld[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      act_q    <= 1'b0;
      din_q    <= '0;
      page_q   <= '0;
      off_q    <= '0;
      cyc_open <= 1'b0;
      wcnt     <= '0;
      pcnt     <= '0;
      vld      <= '0;
      dout_en  <= 1'b0;
    end else begin
      act_q   <= act_s;
      din_q   <= din_s;
      dout_en <= !ce_s && !oe_s && we_s;

      if (accept) begin
        cyc_open <= 1'b1;
        off_q    <= addr_s[PAGE_W-1:0];
        wcnt     <= '0;
        if (state == S_IDLE) begin
          page_q <= addr_s[ADDR_W-1:PAGE_W];
          state  <= S_LOAD;
        end
      end else if (stop) begin
        cyc_open <= 1'b0;
      end

      if (commit) vld[off_q] <= 1'b1;

      case (state)
        S_LOAD: if (!accept) begin
          if (wcnt != WIN_L) wcnt <= wcnt + 1'b1;
          else if (!cyc_open) begin
            state <= S_PROG;
            pcnt  <= '0;
          end
        end
        S_PROG: begin
          if (pcnt == PC_LAST) begin
            state <= S_IDLE;
            vld   <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit) pbuf[off_q] <= din_q;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{page_q, idx}] <= pbuf[idx];
    dout <= mem[addr_s];
  end

  p_no_open_in_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cyc_open);

  p_prog_after_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wcnt) == WIN_L);

  p_wcnt_capped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WIN_L);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pcnt != PC_LAST |=> busy);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pcnt == PC_LAST |=> !busy);

  p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOAD && $past(state == S_LOAD) |-> $stable(page_q));

endmodule

// File: tb/tb_eeprom_page_loader.sv
module tb_eeprom_page_loader;
  localparam int CLK_NS = 10;
  localparam int AW = 8, DW = 8, PW = 3, WIN = 40, PROG = 24, SN = 2;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy;

  int checks = 0, fails = 0;
  logic [7:0] exp_mem [NADDR];

  eeprom_page_loader #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .WIN_CYC(WIN),
                       .PROG_CYC(PROG), .SYNC_N(SN)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // One write cycle; ce_ctl picks chip enable as the later-falling/earlier-rising line.
  task automatic wr(input bit ce_ctl, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a ^ 8'h01; din = ~d;
    if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk); addr = a;
    if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk); addr = a ^ 8'h01; din = d;
    @(negedge clk);
    @(negedge clk); if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk); din = ~d;
    if (ce_ctl) we_n = 1'b1; else ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic en);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [7:0] d; logic en;
    rd(a, d, en);
    chk(en == 1'b1, "R10 read enable", int'(en), 1);
    chk(d == exp_mem[a], tag, int'(d), int'(exp_mem[a]));
  endtask

  task automatic wait_prog(input int base);
    int k = 0, len = 0;
    while (!busy && k < WIN + 40) begin @(negedge clk); k++; end
    chk(base + k >= WIN && base + k <= WIN + 8, "R6 program start delay", base + k, WIN + 4);
    while (busy && len < PROG + 10) begin len++; @(negedge clk); end
    chk(len == PROG, "R7 busy length", len, PROG);
  endtask

  task automatic watch_idle(input int n, input string tag);
    int seen = 0;
    repeat (n) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(dout_en == 1'b0, "R1 dout_en after reset", int'(dout_en), 0);

    // full sweep: every page, both enable orderings
    for (int p = 0; p < NADDR >> PW; p++) begin
      for (int o = 0; o < (1 << PW); o++) begin
        a = 8'((p << PW) | o);
        exp_mem[a] = 8'((p * 37 + o * 11 + 5) & 255);
        wr(o[0], a, exp_mem[a]);
      end
      wait_prog(5);
    end
    for (int i = 0; i < NADDR; i++) rd_chk(8'(i), "R3 R4 R5 sweep readback");

    // R2: output enable low at cycle start
    @(negedge clk); addr = 8'h13; din = 8'hA5; oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout_en == 1'b0, "R10 no read while write enable low", int'(dout_en), 0);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    watch_idle(WIN + 20, "R2 no programming after oe-low cycle");
    rd_chk(8'h13, "R2 location unchanged");

    // R5: off-page load ignored, window not restarted
    exp_mem[8'h22] = 8'h5C;
    wr(1'b0, 8'h22, 8'h5C);
    repeat (15) @(negedge clk);
    wr(1'b1, 8'h6B, 8'hC3);
    wait_prog(27);
    rd_chk(8'h22, "R5 on-page byte stored");
    rd_chk(8'h6B, "R5 off-page byte ignored");
    rd_chk(8'h6A, "R5 neighbour unchanged");

    // R6: gaps just under the window keep the page open
    exp_mem[8'h48] = 8'h11; exp_mem[8'h49] = 8'h22; exp_mem[8'h4A] = 8'h33;
    wr(1'b0, 8'h48, 8'h11);
    watch_idle(28, "R6 page open after first gap");
    wr(1'b1, 8'h49, 8'h22);
    watch_idle(28, "R6 page open after second gap");
    wr(1'b0, 8'h4A, 8'h33);
    wait_prog(5);
    for (int i = 8'h48; i < 8'h50; i++) rd_chk(8'(i), "R6 R9 gapped page readback");

    // R8: write during programming
    exp_mem[8'h50] = 8'h77;
    wr(1'b0, 8'h50, 8'h77);
    while (!busy) @(negedge clk);
    wr(1'b1, 8'h91, 8'h99);
    chk(busy == 1'b1, "R8 write issued inside busy", int'(busy), 1);
    while (busy) @(negedge clk);
    watch_idle(WIN + 20, "R8 no page opened by busy-time write");
    rd_chk(8'h50, "R7 committed byte");
    rd_chk(8'h91, "R8 busy-time write ignored");

    // R9: partial page with a repeated byte
    exp_mem[8'hE1] = 8'h30; exp_mem[8'hE5] = 8'h20; exp_mem[8'hE7] = 8'h40;
    wr(1'b0, 8'hE1, 8'h10);
    wr(1'b1, 8'hE5, 8'h20);
    wr(1'b0, 8'hE1, 8'h30);
    wr(1'b1, 8'hE7, 8'h40);
    wait_prog(5);
    for (int i = 8'hE0; i < 8'hE8; i++) rd_chk(8'(i), "R9 partial page readback");

    repeat (4) @(negedge clk);
    chk(dout_en == 1'b0, "R10 dout_en low when idle", int'(dout_en), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule